// File: doc/BRIEF.md
# Vector-Mask Predicated Execution Unit

This block is a small vector execution engine for conditional loops over short integer vectors. It holds a bank of vector registers and one mask register with a bit per element position. A compare instruction builds the mask from a vector and a scalar. Element-wise subtract and divide instructions then act only on the positions whose mask bit is 1. A clear-mask instruction turns every position back on.

An instruction enters through a valid/ready handshake, one at a time. Elements are handled one per cycle, starting at element 0 and continuing up to the programmed vector length. Predication gates the arithmetic itself, not only the write-back. A disabled element therefore leaves its destination untouched and cannot raise the divide-by-zero exception. It still uses its cycle slot, so run time depends only on the vector length.

The unit has its own element write port and a read port that returns a whole register. These let the surrounding datapath load operands and collect results. A sticky divide-by-zero flag reports exceptions, and a dedicated input clears it.

Top module: `vmask_unit`

## Requirements
- R1: After reset, every mask bit is 1, the vector length equals MVL, the divide-by-zero flag is 0, done is 0, ready is 1, and every vector register element is 0.
- R2: Compare-not-equal (op code 0) sets mask bit i to 1 when element i of the source register differs from the scalar, and to 0 otherwise, for each i below the vector length. It is not predicated. Mask bits at or above the vector length keep their value, and no vector register changes.
- R3: Subtract (op code 1) writes (a[i] - b[i]) mod 2^W to destination element i only where i is below the vector length and mask bit i is 1. All other destination elements keep their value.
- R4: Divide (op code 2) writes the unsigned quotient a[i] / b[i] to destination element i where i is below the vector length and mask bit i is 1. If such an active element has a divisor of 0, the unit writes all ones to that element and sets the divide-by-zero flag.
- R5: A divisor of 0 at a masked-off position, or at a position at or above the vector length, does not set the divide-by-zero flag and does not write that element.
- R6: Clear-mask (op code 3) sets all MVL mask bits to 1 and takes exactly one element slot.
- R7: For op codes 0, 1 and 2, done pulses high for exactly one cycle, exactly VL clock edges after the accepting edge, whatever the mask holds.
- R8: Ready is low from the cycle after acceptance through the done cycle, and high again in the cycle after done. Arithmetic and compare instructions never change the mask.
- R9: A vector-length write is taken only while ready is high and only for values from 1 to MVL. Any other value leaves the vector length unchanged.
- R10: The divide-by-zero flag stays set through later instructions until the clear input is asserted. The clear then drops it to 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Instruction valid |
| in_ready_o | output | 1 | Unit can accept an instruction |
| in_op_i | input | 2 | Op code: 0 compare-ne, 1 subtract, 2 divide, 3 clear-mask |
| in_vd_i | input | RW | Destination register |
| in_va_i | input | RW | First source register |
| in_vb_i | input | RW | Second source register |
| in_scalar_i | input | W | Scalar operand for compare |
| vl_we_i | input | 1 | Vector-length write strobe |
| vl_i | input | LW | New vector length |
| wr_en_i | input | 1 | Element write strobe |
| wr_reg_i | input | RW | Element write register |
| wr_idx_i | input | IW | Element write position |
| wr_data_i | input | W | Element write data |
| rd_sel_i | input | RW | Register selected for readout |
| rd_vec_o | output | MVL*W | Selected register, element i at bits i*W upward |
| mask_o | output | MVL | Mask register |
| vl_o | output | LW | Current vector length |
| done_o | output | 1 | One-cycle completion pulse |
| dz_flag_o | output | 1 | Sticky divide-by-zero flag |
| dz_clr_i | input | 1 | Clear the divide-by-zero flag |

## Verification
The predicated operations run under four mask shapes: all ones after reset or clear, all zeros from comparing a zero vector, alternating bits, and a data-derived mask. The all-ones case confirms plain arithmetic. The all-zeros case shows that nothing is written, no exception is raised and the latency stays at the full vector length. The alternating and data-derived masks catch errors in per-element indexing. The divisor vector holds zeros at both enabled and disabled positions, which separates operation gating from write gating. Shortening the vector length to 3 shows whether elements at or above the length are untouched and whether latency follows that length.

// File: rtl/vmask_pkg.sv
package vmask_pkg;
  typedef enum logic [1:0] {
    OP_CMPNE = 2'd0,
    OP_SUB   = 2'd1,
    OP_DIV   = 2'd2,
    OP_CLRM  = 2'd3
  } vm_op_e;
endpackage

// File: rtl/vmask_seq.sv
module vmask_seq #(
  parameter  int MVL = 8,
  localparam int IW  = (MVL > 1) ? $clog2(MVL) : 1,
  localparam int LW  = $clog2(MVL + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [LW-1:0] len_i,
  output logic          busy_o,
  output logic [IW-1:0] idx_o,
  output logic          done_o
);
  logic [LW-1:0] len_q;
  logic [IW-1:0] idx_q;
  logic          busy_q, done_q, last;

  assign last = (LW'(idx_q) == len_q - LW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        len_q  <= len_i;
      end else if (busy_q) begin
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;
  assign done_o = done_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R8
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (!busy_q && !done_q && len_i != '0));
endmodule

// File: rtl/vmask_alu.sv
module vmask_alu
  import vmask_pkg::*;
#(
  parameter int W = 16
) (
  input  vm_op_e         op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [W-1:0]   s_i,
  input  logic           act_i,
  output logic [W-1:0]   res_o,
  output logic           vec_we_o,
  output logic           mask_we_o,
  output logic           mask_val_o,
  output logic           dz_o
);
  always_comb begin
    res_o      = '0;
    vec_we_o   = 1'b0;
    mask_we_o  = 1'b0;
    mask_val_o = 1'b0;
    dz_o       = 1'b0;
    unique case (op_i)
      OP_CMPNE: begin
        mask_we_o  = 1'b1;
        mask_val_o = (a_i != s_i);
      end
      OP_SUB: begin
        vec_we_o = act_i;
        res_o    = act_i ? (a_i - b_i) : '0;
      end
      OP_DIV: begin
        // gate the divide itself, not only the write
        vec_we_o = act_i;
        dz_o     = act_i && (b_i == '0);
        res_o    = !act_i ? '0 : (b_i == '0) ? '1 : (a_i / b_i);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/vmask_unit.sv
module vmask_unit
  import vmask_pkg::*;
#(
  parameter  int W    = 16,
  parameter  int MVL  = 8,
  parameter  int NREG = 8,
  localparam int IW   = (MVL > 1) ? $clog2(MVL) : 1,
  localparam int LW   = $clog2(MVL + 1),
  localparam int RW   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [1:0]       in_op_i,
  input  logic [RW-1:0]    in_vd_i,
  input  logic [RW-1:0]    in_va_i,
  input  logic [RW-1:0]    in_vb_i,
  input  logic [W-1:0]     in_scalar_i,
  input  logic             vl_we_i,
  input  logic [LW-1:0]    vl_i,
  input  logic             wr_en_i,
  input  logic [RW-1:0]    wr_reg_i,
  input  logic [IW-1:0]    wr_idx_i,
  input  logic [W-1:0]     wr_data_i,
  input  logic [RW-1:0]    rd_sel_i,
  output logic [MVL*W-1:0] rd_vec_o,
  output logic [MVL-1:0]   mask_o,
  output logic [LW-1:0]    vl_o,
  output logic             done_o,
  output logic             dz_flag_o,
  input  logic             dz_clr_i
);
  logic [W-1:0]   vrf_q [NREG][MVL];
  logic [MVL-1:0] mask_q;
  logic [LW-1:0]  vl_q;
  logic           dz_q;

  vm_op_e        op_q;
  logic [RW-1:0] vd_q, va_q, vb_q;
  logic [W-1:0]  sc_q;

  logic          busy, done, accept;
  logic [IW-1:0] idx;
  logic [LW-1:0] start_len;
  logic [W-1:0]  res;
  logic          vec_we, mask_we, mask_val, dz_hit;

  assign in_ready_o = !busy && !done;
  assign accept     = in_valid_i && in_ready_o;
  assign start_len  = (vm_op_e'(in_op_i) == OP_CLRM) ? LW'(1) : vl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q <= OP_CMPNE;
      vd_q <= '0;
      va_q <= '0;
      vb_q <= '0;
      sc_q <= '0;
    end else if (accept) begin
      op_q <= vm_op_e'(in_op_i);
      vd_q <= in_vd_i;
      va_q <= in_va_i;
      vb_q <= in_vb_i;
      sc_q <= in_scalar_i;
    end
  end

  vmask_seq #(.MVL(MVL)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .len_i   (start_len),
    .busy_o  (busy),
    .idx_o   (idx),
    .done_o  (done)
  );

  vmask_alu #(.W(W)) u_alu (
    .op_i       (op_q),
    .a_i        (vrf_q[va_q][idx]),
    .b_i        (vrf_q[vb_q][idx]),
    .s_i        (sc_q),
    .act_i      (mask_q[idx]),
    .res_o      (res),
    .vec_we_o   (vec_we),
    .mask_we_o  (mask_we),
    .mask_val_o (mask_val),
    .dz_o       (dz_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < NREG; r++)
        for (int e = 0; e < MVL; e++)
          vrf_q[r][e] <= '0;
    end else begin
      if (wr_en_i) vrf_q[wr_reg_i][wr_idx_i] <= wr_data_i;
      if (busy && vec_we) vrf_q[vd_q][idx] <= res;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
    end else if (busy) begin
      if (op_q == OP_CLRM) mask_q <= '1;
      else if (mask_we)    mask_q[idx] <= mask_val;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vl_q <= LW'(MVL);
    end else if (vl_we_i && in_ready_o && vl_i != '0 && vl_i <= LW'(MVL)) begin
      vl_q <= vl_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             dz_q <= 1'b0;
    else if (busy && dz_hit) dz_q <= 1'b1;
    else if (dz_clr_i)       dz_q <= 1'b0;
  end

  for (genvar e = 0; e < MVL; e++) begin : g_rd
    assign rd_vec_o[e*W +: W] = vrf_q[rd_sel_i][e];
  end

  assign mask_o    = mask_q;
  assign vl_o      = vl_q;
  assign done_o    = done;
  assign dz_flag_o = dz_q;

  // R8
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !in_ready_o);
  // R8
  arith_mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && (op_q == OP_SUB || op_q == OP_DIV)) |=> $stable(mask_q));
  // R6
  clrm_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && op_q == OP_CLRM) |=> (mask_q == '1 && done_o));
  // R5
  masked_dz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && op_q == OP_DIV && !mask_q[idx] && !dz_q) |=> !dz_q);
  // R9
  vl_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vl_q != '0 && vl_q <= LW'(MVL)));
  // R10
  dz_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dz_q && !dz_clr_i) |=> dz_q);
endmodule

// File: tb/vmask_unit_bench.sv
module vmask_unit_bench;
  import vmask_pkg::*;
  localparam int W = 16, MVL = 8, NREG = 8;
  localparam int IW = 3, LW = 4, RW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             in_valid = 0, in_ready;
  logic [1:0]       in_op = 0;
  logic [RW-1:0]    in_vd = 0, in_va = 0, in_vb = 0;
  logic [W-1:0]     in_scalar = 0;
  logic             vl_we = 0;
  logic [LW-1:0]    vl_in = 0;
  logic             wr_en = 0;
  logic [RW-1:0]    wr_reg = 0;
  logic [IW-1:0]    wr_idx = 0;
  logic [W-1:0]     wr_data = 0;
  logic [RW-1:0]    rd_sel = 0;
  logic [MVL*W-1:0] rd_vec;
  logic [MVL-1:0]   mask;
  logic [LW-1:0]    vl;
  logic             done, dz_flag;
  logic             dz_clr = 0;

  vmask_unit u_vmask_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_op_i(in_op),
    .in_vd_i(in_vd), .in_va_i(in_va), .in_vb_i(in_vb), .in_scalar_i(in_scalar),
    .vl_we_i(vl_we), .vl_i(vl_in),
    .wr_en_i(wr_en), .wr_reg_i(wr_reg), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .rd_sel_i(rd_sel), .rd_vec_o(rd_vec), .mask_o(mask), .vl_o(vl),
    .done_o(done), .dz_flag_o(dz_flag), .dz_clr_i(dz_clr)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  int acc_cyc = 0;

  logic [W-1:0]   m_rf [NREG][MVL];
  logic [MVL-1:0] m_mask;
  int             m_vl;
  logic           m_dz;

  typedef struct {
    int               vd;
    logic [MVL*W-1:0] vec;
    logic [MVL-1:0]   msk;
    logic             dz;
    int               lat;
    string            tag;
  } exp_t;
  exp_t sbq[$];

  task automatic check(input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  function automatic logic [MVL*W-1:0] pack_reg(input int r);
    logic [MVL*W-1:0] v;
    for (int i = 0; i < MVL; i++) v[i*W +: W] = m_rf[r][i];
    return v;
  endfunction

  task automatic load_reg(input int r, input logic [W-1:0] vals [MVL]);
    for (int i = 0; i < MVL; i++) begin
      @(negedge clk);
      wr_en = 1; wr_reg = RW'(r); wr_idx = IW'(i); wr_data = vals[i];
      m_rf[r][i] = vals[i];
    end
    @(negedge clk);
    wr_en = 0;
  endtask

  // driver: model the op, push expectation, then issue it
  task automatic issue(input vm_op_e op, input int vd, input int va, input int vb,
                       input logic [W-1:0] sc, input string tag);
    exp_t e;
    int n;
    n = (op == OP_CLRM) ? 1 : m_vl;
    for (int i = 0; i < m_vl; i++) begin
      case (op)
        OP_CMPNE: m_mask[i] = (m_rf[va][i] != sc);
        OP_SUB:   if (m_mask[i]) m_rf[vd][i] = m_rf[va][i] - m_rf[vb][i];
        OP_DIV:   if (m_mask[i]) begin
                    if (m_rf[vb][i] == 0) begin m_rf[vd][i] = '1; m_dz = 1; end
                    else m_rf[vd][i] = m_rf[va][i] / m_rf[vb][i];
                  end
        default: ;
      endcase
    end
    if (op == OP_CLRM) m_mask = '1;
    e.vd = vd; e.vec = pack_reg(vd); e.msk = m_mask; e.dz = m_dz; e.lat = n; e.tag = tag;
    sbq.push_back(e);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_op = op; in_vd = RW'(vd); in_va = RW'(va); in_vb = RW'(vb);
    in_scalar = sc;
    @(negedge clk);
    in_valid = 0;
    acc_cyc = cyc;
    check({tag, " R8"}, "ready after accept", 128'(in_ready), 128'(0));
    while (sbq.size() != 0) @(negedge clk);
    @(negedge clk);
    check({tag, " R8"}, "ready after done", 128'(in_ready), 128'(1));
  endtask

  task automatic set_vl(input int v);
    @(negedge clk);
    vl_we = 1; vl_in = LW'(v);
    @(negedge clk);
    vl_we = 0;
    if (v >= 1 && v <= MVL) m_vl = v;
    check("R9", "vector length", 128'(vl), 128'(m_vl));
  endtask

  // monitor: pop and compare at each done pulse
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (sbq.size() == 0) begin
          check("R7", "unexpected done", 128'(1), 128'(0));
        end else begin
          e = sbq.pop_front();
          rd_sel = RW'(e.vd);
          #1;
          check({e.tag, " R7"}, "latency", 128'(cyc - acc_cyc), 128'(e.lat));
          check(e.tag, "dest vector", 128'(rd_vec), 128'(e.vec));
          check(e.tag, "mask", 128'(mask), 128'(e.msk));
          check(e.tag, "dz flag", 128'(dz_flag), 128'(e.dz));
          check({e.tag, " R8"}, "ready at done", 128'(in_ready), 128'(0));
          @(negedge clk);
          check({e.tag, " R7"}, "done width", 128'(done), 128'(0));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] va [MVL];
    for (int r = 0; r < NREG; r++) for (int i = 0; i < MVL; i++) m_rf[r][i] = '0;
    m_mask = '1; m_vl = MVL; m_dz = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check("R1", "mask", 128'(mask), 128'({MVL{1'b1}}));
    check("R1", "vl", 128'(vl), 128'(MVL));
    check("R1", "dz flag", 128'(dz_flag), 128'(0));
    check("R1", "ready", 128'(in_ready), 128'(1));
    check("R1", "done", 128'(done), 128'(0));
    rd_sel = 3; #1;
    check("R1", "regs zero", 128'(rd_vec), 128'(0));

    va = '{16'd0, 16'd5, 16'd0, 16'd7, 16'd9, 16'd0, 16'd3, 16'd4}; load_reg(1, va);
    va = '{16'd1, 16'd2, 16'd3, 16'd0, 16'd4, 16'd0, 16'd1, 16'd2}; load_reg(2, va);
    va = '{default: 16'hAAAA}; load_reg(3, va);
    va = '{default: 16'h5555}; load_reg(4, va);
    va = '{16'd1, 16'd0, 16'd1, 16'd0, 16'd1, 16'd0, 16'd1, 16'd0}; load_reg(5, va);

    issue(OP_SUB,   3, 1, 2, 0, "R3 all-ones");
    issue(OP_CMPNE, 2, 2, 0, 0, "R2 data mask");
    issue(OP_DIV,   4, 1, 2, 0, "R5 masked zero divisors");
    issue(OP_CLRM,  0, 0, 0, 0, "R6 clear");
    issue(OP_DIV,   4, 1, 2, 0, "R4 active zero divisors");
    issue(OP_CMPNE, 5, 5, 0, 0, "R2 alternating");
    issue(OP_SUB,   3, 2, 1, 0, "R3 alternating / R10 sticky");
    @(negedge clk); dz_clr = 1;
    @(negedge clk); dz_clr = 0; m_dz = 0;
    check("R10", "dz cleared", 128'(dz_flag), 128'(0));
    issue(OP_CMPNE, 6, 6, 0, 0, "R2 all-zero");
    issue(OP_DIV,   3, 1, 6, 0, "R5 all-zero mask");
    issue(OP_SUB,   4, 1, 2, 0, "R3 all-zero mask");
    set_vl(0);
    set_vl(9);
    set_vl(3);
    issue(OP_CLRM,  0, 0, 0, 0, "R6 clear short VL");
    issue(OP_CMPNE, 1, 1, 0, 0, "R2 short VL");
    issue(OP_CMPNE, 1, 1, 0, 5, "R2 scalar 5");
    issue(OP_SUB,   3, 1, 2, 0, "R3 short VL");
    issue(OP_CLRM,  0, 0, 0, 0, "R6 restore");
    issue(OP_DIV,   3, 1, 6, 0, "R4 short VL zero divisors");
    issue(OP_DIV,   3, 2, 6, 0, "R10 sticky repeat");
    set_vl(8);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule